// File: doc/BRIEF.md
# Clause-Based Batch Dispatch Scheduler

This block keeps a small pool of fragment batches in flight and decides, cycle by cycle, which batch goes to the arithmetic pipeline and which batch goes to the texture unit. Each shader is cut into clauses at every texture fetch, so no clause holds a fetch. A batch moves through its clauses one at a time. A clause is sent to the arithmetic pipeline only once all its inputs are present: the fragment inputs, the registers written by the batch's previous clause, and, if a fetch comes before the clause, that fetch's result. The texture port runs on its own eligibility, so fetches for one batch can be in flight while another batch computes. Latency is hidden by moving between many short batches, not by running one long batch.

A batch is admitted with the index of its last clause and a per-clause fetch mask. Bit k of the mask set means clause k is preceded by a fetch whose result it consumes. The scheduler places the batch in the lowest free slot and returns that slot number as the batch tag. A separate per-slot strobe marks a slot's fragment inputs as arrived. The arithmetic pipeline reports each finished clause by tag. The texture unit returns results by tag, in any order. The scheduler echoes each finished clause one cycle later. On the final clause it also raises a retire pulse and frees the slot.

Back-pressure rules. Admission fires when `new_valid` and `new_ready` are both high at a clock edge. Each request port (`alu_req_*`, `tex_req_*`) fires when valid and ready are both high. Once a request's valid is raised it stays high, with tag and clause unchanged, until ready is seen. The completion and return inputs have no ready: they are always taken.

Top module: `clause_sched`

## Requirements
- R1: `new_ready` is high exactly when at least one slot is free, and `new_id` then gives the lowest-numbered free slot. An admitted batch starts at clause 0 with its fragment inputs absent. While no slot is free, an admission attempt changes nothing.
- R2: No clause of a batch is offered to the arithmetic port before a `frag_set` bit for its slot has been seen. A `frag_set` bit for a free slot has no effect.
- R3: When bit k of the batch's fetch mask is set, clause k is not offered to the arithmetic port until a texture return carrying that batch's tag has arrived after the fetch was issued.
- R4: A fetch for clause k is offered only after the batch's fragment inputs are present and clause k-1 has been reported complete. A fetch is offered and accepted regardless of whether the arithmetic port is stalled.
- R5: A batch has at most one clause in the arithmetic pipeline. Its next clause is not offered until completion of the current one is reported. A completion for a slot with no clause in flight is ignored.
- R6: Each request port grants, among eligible slots, the first one in ascending cyclic order that follows the slot it last granted. The two ports keep separate pointers.
- R7: Once a request port raises valid, valid, tag and clause stay unchanged until the cycle ready is high.
- R8: Texture results may return in any order. A return sets the ready flag only for the slot named by its tag. A return for a slot with no fetch outstanding is ignored.
- R9: One cycle after an accepted completion, `clause_done_valid` pulses with that slot's tag and the index of the clause that finished.
- R10: When the finished clause is the batch's last, `batch_done_valid` pulses in the same cycle as `clause_done_valid`, with the same tag, and the slot is free for admission in that cycle.
- R11: After reset both request ports are idle, both pulse outputs are low, `new_ready` is high and `new_id` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| new_valid | input | 1 | Batch admission request |
| new_ready | output | 1 | A slot is free |
| new_last_clause | input | CW | Index of the batch's final clause |
| new_tex_mask | input | MAX_CLAUSES | Bit k: clause k consumes a preceding fetch |
| new_id | output | IDW | Slot assigned on admission |
| frag_set | input | NUM_SLOTS | Per-slot strobe: fragment inputs have arrived |
| alu_req_valid | output | 1 | Clause offered to arithmetic pipeline |
| alu_req_ready | input | 1 | Arithmetic pipeline accepts |
| alu_req_id | output | IDW | Tag of offered batch |
| alu_req_clause | output | CW | Clause index offered |
| alu_cmp_valid | input | 1 | Arithmetic pipeline finished a clause |
| alu_cmp_id | input | IDW | Tag of finished clause |
| tex_req_valid | output | 1 | Fetch offered to texture unit |
| tex_req_ready | input | 1 | Texture unit accepts |
| tex_req_id | output | IDW | Tag of fetching batch |
| tex_req_clause | output | CW | Clause that consumes the fetch |
| tex_ret_valid | input | 1 | Texture result returned |
| tex_ret_id | input | IDW | Tag of returned result |
| clause_done_valid | output | 1 | Clause completion pulse |
| clause_done_id | output | IDW | Tag of completed clause |
| clause_done_idx | output | CW | Index of completed clause |
| batch_done_valid | output | 1 | Batch retired, slot freed |
| batch_done_id | output | IDW | Tag of retired batch |

## Verification
The bench builds the block with its defaults: eight slots and up to eight clauses. With eight slots, the pool can be filled completely, so the refused-admission case and slot reuse after retirement are both reachable. Three batches made eligible together show the cyclic grant order wrapping past the top slot. Two fetches returned in reverse order, while the arithmetic port is held stalled, exercise the independence of the two ports and the request hold rule.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // Life cycle of one batch slot.
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,  // no batch held
    SLOT_WAIT = 2'd1,  // batch held, gathering inputs for its next clause
    SLOT_BUSY = 2'd2   // a clause of this batch is in the arithmetic pipeline
  } slot_phase_e;
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          accept_i,
  output logic          valid_o,
  output logic [IW-1:0] id_o
);
  logic [IW-1:0] last_q;
  logic [IW-1:0] held_id_q;
  logic          held_q;
  logic [IW-1:0] pick;
  logic          found;

  // Cyclic search starting just above the last granted slot.
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(last_q) + k) % N;
      if (!found && req_i[c]) begin
        found = 1'b1;
        pick  = IW'(c);
      end
    end
  end

  assign valid_o = |req_i;
  assign id_o    = held_q ? held_id_q : pick;

  // A stalled offer is frozen until accepted; eligibility only drops on issue.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q    <= IW'(N - 1);
      held_q    <= 1'b0;
      held_id_q <= '0;
    end else if (valid_o && accept_i) begin
      last_q <= id_o;
      held_q <= 1'b0;
    end else if (valid_o) begin
      held_q    <= 1'b1;
      held_id_q <= id_o;
    end else begin
      held_q <= 1'b0;
    end
  end
endmodule

// File: rtl/batch_slot.sv
module batch_slot
  import sched_pkg::*;
#(
  parameter int MAX_CLAUSES = 8,
  parameter int CW          = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_i,
  input  logic [CW-1:0]          alloc_last_i,
  input  logic [MAX_CLAUSES-1:0] alloc_mask_i,
  input  logic                   frag_i,
  input  logic                   alu_issue_i,
  input  logic                   alu_cmp_i,
  input  logic                   tex_issue_i,
  input  logic                   tex_ret_i,
  output logic                   free_o,
  output logic                   alu_elig_o,
  output logic                   tex_elig_o,
  output logic                   busy_o,
  output logic                   last_o,
  output logic [CW-1:0]          clause_o
);
  slot_phase_e            phase_q;
  logic [CW-1:0]          clause_q;
  logic [CW-1:0]          last_q;
  logic [MAX_CLAUSES-1:0] mask_q;
  logic                   frag_q;   // fragment inputs present
  logic                   texr_q;   // fetch result for current clause present
  logic                   texo_q;   // fetch for current clause outstanding
  logic                   need_tex;

  assign need_tex   = mask_q[clause_q];
  assign free_o     = (phase_q == SLOT_FREE);
  assign busy_o     = (phase_q == SLOT_BUSY);
  assign last_o     = (clause_q == last_q);
  assign clause_o   = clause_q;
  // Register inputs from the previous clause are present whenever no clause is in flight.
  assign alu_elig_o = (phase_q == SLOT_WAIT) && frag_q && (!need_tex || texr_q);
  assign tex_elig_o = (phase_q == SLOT_WAIT) && frag_q && need_tex && !texr_q && !texo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= SLOT_FREE;
      clause_q <= '0;
      last_q   <= '0;
      mask_q   <= '0;
      frag_q   <= 1'b0;
      texr_q   <= 1'b0;
      texo_q   <= 1'b0;
    end else if (alloc_i) begin
      phase_q  <= SLOT_WAIT;
      clause_q <= '0;
      last_q   <= alloc_last_i;
      mask_q   <= alloc_mask_i;
      frag_q   <= 1'b0;
      texr_q   <= 1'b0;
      texo_q   <= 1'b0;
    end else begin
      if (frag_i && phase_q != SLOT_FREE) frag_q <= 1'b1;
      if (tex_issue_i) texo_q <= 1'b1;
      if (tex_ret_i && texo_q) begin
        texo_q <= 1'b0;
        texr_q <= 1'b1;
      end
      if (alu_issue_i) phase_q <= SLOT_BUSY;
      if (alu_cmp_i && phase_q == SLOT_BUSY) begin
        texr_q <= 1'b0;
        if (last_o) begin
          phase_q <= SLOT_FREE;
          frag_q  <= 1'b0;
        end else begin
          phase_q  <= SLOT_WAIT;
          clause_q <= clause_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clause_sched.sv
module clause_sched
  import sched_pkg::*;
#(
  parameter int NUM_SLOTS   = 8,
  parameter int MAX_CLAUSES = 8,
  localparam int IDW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CW  = (MAX_CLAUSES > 1) ? $clog2(MAX_CLAUSES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   new_valid,
  output logic                   new_ready,
  input  logic [CW-1:0]          new_last_clause,
  input  logic [MAX_CLAUSES-1:0] new_tex_mask,
  output logic [IDW-1:0]         new_id,
  input  logic [NUM_SLOTS-1:0]   frag_set,
  output logic                   alu_req_valid,
  input  logic                   alu_req_ready,
  output logic [IDW-1:0]         alu_req_id,
  output logic [CW-1:0]          alu_req_clause,
  input  logic                   alu_cmp_valid,
  input  logic [IDW-1:0]         alu_cmp_id,
  output logic                   tex_req_valid,
  input  logic                   tex_req_ready,
  output logic [IDW-1:0]         tex_req_id,
  output logic [CW-1:0]          tex_req_clause,
  input  logic                   tex_ret_valid,
  input  logic [IDW-1:0]         tex_ret_id,
  output logic                   clause_done_valid,
  output logic [IDW-1:0]         clause_done_id,
  output logic [CW-1:0]          clause_done_idx,
  output logic                   batch_done_valid,
  output logic [IDW-1:0]         batch_done_id
);
  logic [NUM_SLOTS-1:0] free_w, alu_elig, tex_elig, busy_w, last_w;
  logic [NUM_SLOTS-1:0] alloc_w, alu_issue, alu_cmp, tex_issue, tex_ret;
  logic [CW-1:0]        clause_w [NUM_SLOTS];
  logic                 alu_fire, tex_fire, cmp_hit, free_found;

  // Lowest free slot receives the next batch.
  always_comb begin
    new_id     = '0;
    free_found = 1'b0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (!free_found && free_w[k]) begin
        free_found = 1'b1;
        new_id     = IDW'(k);
      end
    end
  end
  assign new_ready = |free_w;

  assign alu_fire = alu_req_valid && alu_req_ready;
  assign tex_fire = tex_req_valid && tex_req_ready;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign alloc_w[g]   = new_valid && new_ready && (new_id == IDW'(g));
    assign alu_issue[g] = alu_fire && (alu_req_id == IDW'(g));
    assign tex_issue[g] = tex_fire && (tex_req_id == IDW'(g));
    assign alu_cmp[g]   = alu_cmp_valid && (alu_cmp_id == IDW'(g));
    assign tex_ret[g]   = tex_ret_valid && (tex_ret_id == IDW'(g));

    batch_slot #(.MAX_CLAUSES(MAX_CLAUSES), .CW(CW)) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (alloc_w[g]),
      .alloc_last_i (new_last_clause),
      .alloc_mask_i (new_tex_mask),
      .frag_i       (frag_set[g]),
      .alu_issue_i  (alu_issue[g]),
      .alu_cmp_i    (alu_cmp[g]),
      .tex_issue_i  (tex_issue[g]),
      .tex_ret_i    (tex_ret[g]),
      .free_o       (free_w[g]),
      .alu_elig_o   (alu_elig[g]),
      .tex_elig_o   (tex_elig[g]),
      .busy_o       (busy_w[g]),
      .last_o       (last_w[g]),
      .clause_o     (clause_w[g])
    );
  end

  rr_arbiter #(.N(NUM_SLOTS), .IW(IDW)) u_alu_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (alu_elig),
    .accept_i (alu_req_ready),
    .valid_o  (alu_req_valid),
    .id_o     (alu_req_id)
  );

  rr_arbiter #(.N(NUM_SLOTS), .IW(IDW)) u_tex_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (tex_elig),
    .accept_i (tex_req_ready),
    .valid_o  (tex_req_valid),
    .id_o     (tex_req_id)
  );

  assign alu_req_clause = clause_w[alu_req_id];
  assign tex_req_clause = clause_w[tex_req_id];
  assign cmp_hit        = alu_cmp_valid && busy_w[alu_cmp_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clause_done_valid <= 1'b0;
      clause_done_id    <= '0;
      clause_done_idx   <= '0;
      batch_done_valid  <= 1'b0;
      batch_done_id     <= '0;
    end else begin
      clause_done_valid <= cmp_hit;
      batch_done_valid  <= cmp_hit && last_w[alu_cmp_id];
      if (cmp_hit) begin
        clause_done_id  <= alu_cmp_id;
        clause_done_idx <= clause_w[alu_cmp_id];
        batch_done_id   <= alu_cmp_id;
      end
    end
  end
endmodule

// File: rtl/clause_sched_chk.sv
module clause_sched_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int IDW       = 3,
  parameter int CW        = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           alu_req_valid,
  input logic           alu_req_ready,
  input logic [IDW-1:0] alu_req_id,
  input logic [CW-1:0]  alu_req_clause,
  input logic           alu_cmp_valid,
  input logic [IDW-1:0] alu_cmp_id,
  input logic           tex_req_valid,
  input logic           tex_req_ready,
  input logic [IDW-1:0] tex_req_id,
  input logic           tex_ret_valid,
  input logic [IDW-1:0] tex_ret_id,
  input logic           clause_done_valid,
  input logic [IDW-1:0] clause_done_id,
  input logic           batch_done_valid,
  input logic [IDW-1:0] batch_done_id
);
  logic [NUM_SLOTS-1:0] busy_sh;
  logic [NUM_SLOTS-1:0] texo_sh;
  logic                 alu_fire, tex_fire;

  assign alu_fire = alu_req_valid && alu_req_ready;
  assign tex_fire = tex_req_valid && tex_req_ready;

  // Shadow bookkeeping built only from port traffic.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_sh <= '0;
      texo_sh <= '0;
    end else begin
      if (alu_cmp_valid) busy_sh[alu_cmp_id] <= 1'b0;
      if (alu_fire)      busy_sh[alu_req_id] <= 1'b1;
      if (tex_ret_valid) texo_sh[tex_ret_id] <= 1'b0;
      if (tex_fire)      texo_sh[tex_req_id] <= 1'b1;
    end
  end

  p_alu_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alu_req_valid && !alu_req_ready |=> alu_req_valid && $stable(alu_req_id) && $stable(alu_req_clause));

  p_tex_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tex_req_valid && !tex_req_ready |=> tex_req_valid && $stable(tex_req_id));

  p_no_alu_with_fetch_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alu_fire |-> !texo_sh[alu_req_id]);

  p_one_clause_in_flight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alu_fire |-> !busy_sh[alu_req_id]);

  p_done_follows_cmp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clause_done_valid |-> $past(alu_cmp_valid) && ($past(alu_cmp_id) == clause_done_id));

  p_retire_with_clause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    batch_done_valid |-> clause_done_valid && (clause_done_id == batch_done_id));
endmodule

bind clause_sched clause_sched_chk #(.NUM_SLOTS(NUM_SLOTS), .IDW(IDW), .CW(CW)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .alu_req_valid     (alu_req_valid),
  .alu_req_ready     (alu_req_ready),
  .alu_req_id        (alu_req_id),
  .alu_req_clause    (alu_req_clause),
  .alu_cmp_valid     (alu_cmp_valid),
  .alu_cmp_id        (alu_cmp_id),
  .tex_req_valid     (tex_req_valid),
  .tex_req_ready     (tex_req_ready),
  .tex_req_id        (tex_req_id),
  .tex_ret_valid     (tex_ret_valid),
  .tex_ret_id        (tex_ret_id),
  .clause_done_valid (clause_done_valid),
  .clause_done_id    (clause_done_id),
  .batch_done_valid  (batch_done_valid),
  .batch_done_id     (batch_done_id)
);

// File: tb/test_clause_sched.sv
module test_clause_sched;
  localparam int NS = 8;
  localparam int MC = 8;
  localparam int IW = 3;
  localparam int CW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          new_valid, new_ready;
  logic [CW-1:0] new_last_clause;
  logic [MC-1:0] new_tex_mask;
  logic [IW-1:0] new_id;
  logic [NS-1:0] frag_set;
  logic          alu_req_valid, alu_req_ready;
  logic [IW-1:0] alu_req_id;
  logic [CW-1:0] alu_req_clause;
  logic          alu_cmp_valid;
  logic [IW-1:0] alu_cmp_id;
  logic          tex_req_valid, tex_req_ready;
  logic [IW-1:0] tex_req_id;
  logic [CW-1:0] tex_req_clause;
  logic          tex_ret_valid;
  logic [IW-1:0] tex_ret_id;
  logic          clause_done_valid;
  logic [IW-1:0] clause_done_id;
  logic [CW-1:0] clause_done_idx;
  logic          batch_done_valid;
  logic [IW-1:0] batch_done_id;

  clause_sched #(.NUM_SLOTS(NS), .MAX_CLAUSES(MC)) i_clause_sched (.*);

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic expect_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic admit(input int last, input int mask, input int exp_id);
    @(negedge clk);
    new_valid = 1'b1; new_last_clause = CW'(last); new_tex_mask = MC'(mask);
    #1;
    expect_eq("R1 new_ready", int'(new_ready), 1);
    expect_eq("R1 new_id", int'(new_id), exp_id);
    @(negedge clk);
    new_valid = 1'b0;
  endtask

  task automatic fill(input int mask);
    @(negedge clk); frag_set = NS'(mask);
    @(negedge clk); frag_set = '0;
  endtask

  task automatic alu_take(input string tag, input int exp_id, input int exp_cl);
    @(negedge clk); #1;
    expect_eq({tag, " alu_req_valid"}, int'(alu_req_valid), 1);
    expect_eq({tag, " alu_req_id"}, int'(alu_req_id), exp_id);
    expect_eq({tag, " alu_req_clause"}, int'(alu_req_clause), exp_cl);
    alu_req_ready = 1'b1;
    @(negedge clk); alu_req_ready = 1'b0;
  endtask

  task automatic tex_take(input string tag, input int exp_id, input int exp_cl);
    @(negedge clk); #1;
    expect_eq({tag, " tex_req_valid"}, int'(tex_req_valid), 1);
    expect_eq({tag, " tex_req_id"}, int'(tex_req_id), exp_id);
    expect_eq({tag, " tex_req_clause"}, int'(tex_req_clause), exp_cl);
    tex_req_ready = 1'b1;
    @(negedge clk); tex_req_ready = 1'b0;
  endtask

  task automatic complete(input int id, input int exp_v, input int exp_idx, input int exp_b);
    @(negedge clk); alu_cmp_valid = 1'b1; alu_cmp_id = IW'(id);
    @(negedge clk); alu_cmp_valid = 1'b0;
    #1;
    expect_eq("R9 clause_done_valid", int'(clause_done_valid), exp_v);
    if (exp_v != 0) begin
      expect_eq("R9 clause_done_id", int'(clause_done_id), id);
      expect_eq("R9 clause_done_idx", int'(clause_done_idx), exp_idx);
    end
    expect_eq("R10 batch_done_valid", int'(batch_done_valid), exp_b);
    if (exp_b != 0) expect_eq("R10 batch_done_id", int'(batch_done_id), id);
  endtask

  task automatic tex_return(input int id);
    @(negedge clk); tex_ret_valid = 1'b1; tex_ret_id = IW'(id);
    @(negedge clk); tex_ret_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    expect_eq("R11 alu_req_valid", int'(alu_req_valid), 0);
    expect_eq("R11 tex_req_valid", int'(tex_req_valid), 0);
    expect_eq("R11 clause_done_valid", int'(clause_done_valid), 0);
    expect_eq("R11 batch_done_valid", int'(batch_done_valid), 0);
    expect_eq("R11 new_ready", int'(new_ready), 1);
    expect_eq("R11 new_id", int'(new_id), 0);
  endtask

  // Two clauses, the second behind a fetch.
  task automatic t_single_batch;
    admit(1, 'b10, 0);
    fill(1 << 5); #1;
    expect_eq("R2 no alu before fill", int'(alu_req_valid), 0);
    expect_eq("R2 empty fill ignored, new_id", int'(new_id), 1);
    fill(1); #1;
    expect_eq("R2 alu after fill", int'(alu_req_valid), 1);
    expect_eq("R4 no fetch for clause 0", int'(tex_req_valid), 0);
    repeat (3) @(negedge clk);
    #1;
    expect_eq("R7 held valid", int'(alu_req_valid), 1);
    expect_eq("R7 held id", int'(alu_req_id), 0);
    alu_take("R2", 0, 0); #1;
    expect_eq("R5 no reissue in flight", int'(alu_req_valid), 0);
    expect_eq("R4 fetch waits on clause 0", int'(tex_req_valid), 0);
    complete(0, 1, 0, 0);
    expect_eq("R3 alu waits fetch", int'(alu_req_valid), 0);
    tex_take("R4", 0, 1); #1;
    expect_eq("R4 single fetch", int'(tex_req_valid), 0);
    tex_return(3); #1;
    expect_eq("R8 stray return ignored", int'(alu_req_valid), 0);
    tex_return(0);
    alu_take("R3", 0, 1);
    complete(0, 1, 1, 1);
    expect_eq("R10 slot freed ready", int'(new_ready), 1);
    expect_eq("R10 slot freed id", int'(new_id), 0);
  endtask

  task automatic t_round_robin;
    admit(0, 0, 0); admit(0, 0, 1); admit(0, 0, 2);
    fill('b111);
    alu_take("R6 first after 0", 1, 0);
    alu_take("R6 next", 2, 0);
    alu_take("R6 wrap", 0, 0);
    complete(1, 1, 0, 1);
    complete(2, 1, 0, 1);
    complete(0, 1, 0, 1);
  endtask

  task automatic t_decoupled;
    admit(0, 1, 0); admit(0, 1, 1); admit(0, 0, 2);
    fill('b111); #1;
    expect_eq("R4 alu offer id", int'(alu_req_id), 2);
    tex_take("R6 tex after 0", 1, 0); #1;
    expect_eq("R4 alu still stalled", int'(alu_req_valid), 1);
    tex_take("R6 tex wrap", 0, 0);
    tex_return(0); #1;
    expect_eq("R7 held id over new ready", int'(alu_req_id), 2);
    alu_take("R7", 2, 0);
    alu_take("R8 out of order return", 0, 0); #1;
    expect_eq("R3 slot 1 waits", int'(alu_req_valid), 0);
    tex_return(1);
    alu_take("R8", 1, 0);
    complete(2, 1, 0, 1);
    complete(0, 1, 0, 1);
    complete(1, 1, 0, 1);
  endtask

  task automatic t_full_pool;
    for (int k = 0; k < NS; k++) admit(0, 0, k);
    #1;
    expect_eq("R1 pool full", int'(new_ready), 0);
    @(negedge clk); new_valid = 1'b1;
    @(negedge clk); new_valid = 1'b0;
    #1;
    expect_eq("R1 refused admission", int'(new_ready), 0);
    fill(1 << 3);
    alu_take("R1", 3, 0);
    complete(3, 1, 0, 1);
    expect_eq("R10 reuse ready", int'(new_ready), 1);
    expect_eq("R10 reuse id", int'(new_id), 3);
  endtask

  task automatic t_in_flight;
    admit(2, 0, 3);
    fill(1 << 3);
    alu_take("R5", 3, 0); #1;
    expect_eq("R5 one in flight", int'(alu_req_valid), 0);
    complete(5, 0, 0, 0);
    complete(3, 1, 0, 0);
    expect_eq("R5 next clause offered", int'(alu_req_valid), 1);
    expect_eq("R5 next clause index", int'(alu_req_clause), 1);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    rst_n = 1'b0; new_valid = 1'b0; new_last_clause = '0; new_tex_mask = '0;
    frag_set = '0; alu_req_ready = 1'b0; alu_cmp_valid = 1'b0; alu_cmp_id = '0;
    tex_req_ready = 1'b0; tex_ret_valid = 1'b0; tex_ret_id = '0;
    t_reset();
    t_single_batch();
    t_round_robin();
    t_decoupled();
    t_full_pool();
    t_in_flight();
    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end
endmodule